// File: doc/BRIEF.md
# Frame-Synced Serial Result Receiver

This block sits on the host side of a sampling converter that drives its own serial data clock. When the host wants a sample it triggers a short active-low convert strobe. The converter then starts a new conversion. While that conversion runs, it holds its busy line low and shifts out the result of the *previous* conversion on its data line, timed by its own clock.

The receiver passes the converter's clock, data and busy lines through multi-flop synchronisers into the system clock domain. A falling edge of the synchronised busy line opens a frame and a rising edge closes it. While a frame is open, a data bit is taken on each detected rising edge of the synchronised serial clock, MSB first.

At the end of a frame that carried a full 12-bit two's-complement word, the block presents the word sign-extended to 16 bits with a one-cycle valid pulse. A frame that closes early is reported as short. Because each frame carries the previous conversion's result, the first word delivered after reset is marked stale.

Top module: `adc_frame_rx`

## Requirements
- R1: A high level on `start_i`, sampled while no strobe is in progress, drives `conv_n_o` low from the next clock edge for exactly PULSE_CYCLES (default 4) system cycles, after which it returns high.
- R2: `start_i` sampled while a strobe is in progress has no effect: the strobe still ends PULSE_CYCLES cycles after it began.
- R3: Within a frame (from a falling edge of synchronised busy up to the next rising edge), each rising edge of the synchronised serial clock shifts in the data line, the first bit received being bit 11 of the word.
- R4: When busy rises after exactly 12 bits, `valid_o` is high for exactly one cycle, asserted by the third system clock edge after busy is seen high at the input, and `word_o` then holds the received word.
- R5: `word_o[15:12]` are copies of received bit 11 (sign extension of the two's-complement word).
- R6: When busy rises after fewer than 12 bits, `short_o` pulses for one cycle with the same timing as R4, `valid_o` stays low and `word_o` keeps its previous value.
- R7: Serial clock edges after the 12th bit in a frame are ignored: the word is formed from the first 12 bits.
- R8: `stale_o` is high together with `valid_o` only for the first frame that ends after reset. Any first frame end clears this condition, including a short one.
- R9: During and right after reset, `conv_n_o` is 1 and `valid_o`, `short_o`, `stale_o` and `word_o` are 0.
- R10: Serial clock activity while busy is high produces neither `valid_o` nor `short_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a convert strobe |
| conv_n_o | output | 1 | Active-low convert strobe to the converter |
| adc_sclk_i | input | 1 | Serial clock driven by the converter (asynchronous) |
| adc_data_i | input | 1 | Serial data from the converter (asynchronous) |
| adc_busy_i | input | 1 | Busy line from the converter, low during a frame (asynchronous) |
| word_o | output | OUT_BITS (16) | Last full word, sign-extended |
| valid_o | output | 1 | One-cycle pulse: new full word on `word_o` |
| short_o | output | 1 | One-cycle pulse: frame ended with too few bits |
| stale_o | output | 1 | With `valid_o`: word is the first after reset |

## Verification
The convert strobe appears one edge after `start_i` is sampled, so the bench drives `start_i` at a falling edge and reads `conv_n_o` at each following falling edge, counting PULSE_CYCLES low samples.

Frame results cross two synchroniser flops and one output register. The bench therefore raises busy at a falling edge and requires the result pulse to be absent after two rising edges, present after the third, and gone after the fourth, each read at the falling edge in between.

Serial bits are driven with the data settled several system cycles before each serial clock rise, so synchroniser alignment cannot blur which bit is taken.

// File: rtl/adcrx_pkg.sv
package adcrx_pkg;
  // Frame tracking state of the receiver
  typedef enum logic {
    FR_IDLE   = 1'b0,
    FR_ACTIVE = 1'b1
  } frame_state_e;

  // Indices of the converter lines inside the synchroniser bundle
  localparam int LN_SCLK = 0;
  localparam int LN_DATA = 1;
  localparam int LN_BUSY = 2;
  localparam int LN_COUNT = 3;
endpackage

// File: rtl/adcrx_sync.sv
module adcrx_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= RESET_VAL;
          else        q <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= RESET_VAL;
          else        q <= g_stage[s-1].q;
        end
      end
    end
  endgenerate

  assign sync_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/adcrx_conv_pulse.sv
module adcrx_conv_pulse #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic conv_n_o,
  output logic fire_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_CYCLES);

  logic [PW-1:0] remain_q;
  logic          idle;

  assign idle   = (remain_q == '0);
  assign fire_o = start_i && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      conv_n_o <= 1'b1;
    end else if (fire_o) begin
      remain_q <= LOAD - 1'b1;
      conv_n_o <= 1'b0;
    end else if (!idle) begin
      remain_q <= remain_q - 1'b1;
      conv_n_o <= 1'b0;
    end else begin
      conv_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/adcrx_frame.sv
module adcrx_frame
  import adcrx_pkg::*;
#(
  parameter int WORD_BITS = 12,
  parameter int OUT_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_s,
  input  logic                data_s,
  input  logic                busy_s,
  output logic [OUT_BITS-1:0] word_o,
  output logic                valid_o,
  output logic                short_o,
  output logic                stale_o,
  output logic                bit_strobe_o,
  output logic                frame_end_o
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_BITS);

  function automatic logic [OUT_BITS-1:0] widen(input logic [WORD_BITS-1:0] w);
    return {{(OUT_BITS - WORD_BITS){w[WORD_BITS-1]}}, w};
  endfunction

  frame_state_e         state_q;
  logic                 sclk_q, busy_q, first_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [WORD_BITS-1:0] shreg_q;
  logic                 sclk_rise, busy_fall, busy_rise, full;

  assign sclk_rise    = sclk_s && !sclk_q;
  assign busy_fall    = !busy_s && busy_q;
  assign busy_rise    = busy_s && !busy_q;
  assign full         = (cnt_q == FULL_CNT);
  assign bit_strobe_o = sclk_rise && !busy_s && (state_q == FR_ACTIVE) && !full;
  assign frame_end_o  = busy_rise && (state_q == FR_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      sclk_q  <= 1'b0;
      busy_q  <= 1'b1;
      first_q <= 1'b1;
      cnt_q   <= '0;
      shreg_q <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
      short_o <= 1'b0;
      stale_o <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      busy_q  <= busy_s;
      valid_o <= 1'b0;
      short_o <= 1'b0;
      stale_o <= 1'b0;
      if (busy_fall) begin
        state_q <= FR_ACTIVE;
        cnt_q   <= '0;
      end else if (frame_end_o) begin
        state_q <= FR_IDLE;
        first_q <= 1'b0;
        if (full) begin
          valid_o <= 1'b1;
          stale_o <= first_q;
          word_o  <= widen(shreg_q);
        end else begin
          short_o <= 1'b1;
        end
      end else if (bit_strobe_o) begin
        shreg_q <= {shreg_q[WORD_BITS-2:0], data_s};
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adcrx_pkg::*;
#(
  parameter int WORD_BITS = 12,
  parameter int OUT_BITS = 16,
  parameter int PULSE_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                conv_n_o,
  input  logic                adc_sclk_i,
  input  logic                adc_data_i,
  input  logic                adc_busy_i,
  output logic [OUT_BITS-1:0] word_o,
  output logic                valid_o,
  output logic                short_o,
  output logic                stale_o
);
  localparam logic [LN_COUNT-1:0] LINE_RESET = LN_COUNT'(1) << LN_BUSY;

  logic [LN_COUNT-1:0] lines_raw, lines_s;
  logic                conv_fire, bit_strobe, frame_end;

  always_comb begin
    lines_raw          = '0;
    lines_raw[LN_SCLK] = adc_sclk_i;
    lines_raw[LN_DATA] = adc_data_i;
    lines_raw[LN_BUSY] = adc_busy_i;
  end

  adcrx_sync #(
    .WIDTH(LN_COUNT), .STAGES(SYNC_STAGES), .RESET_VAL(LINE_RESET)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(lines_raw), .sync_o(lines_s)
  );

  adcrx_conv_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_conv (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .conv_n_o(conv_n_o), .fire_o(conv_fire)
  );

  adcrx_frame #(.WORD_BITS(WORD_BITS), .OUT_BITS(OUT_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(lines_s[LN_SCLK]), .data_s(lines_s[LN_DATA]), .busy_s(lines_s[LN_BUSY]),
    .word_o(word_o), .valid_o(valid_o), .short_o(short_o), .stale_o(stale_o),
    .bit_strobe_o(bit_strobe), .frame_end_o(frame_end)
  );
endmodule

// File: rtl/adcrx_checker.sv
module adcrx_checker #(
  parameter int WORD_BITS = 12,
  parameter int OUT_BITS = 16,
  parameter int PULSE_CYCLES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                conv_n_o,
  input logic [OUT_BITS-1:0] word_o,
  input logic                valid_o,
  input logic                short_o,
  input logic                stale_o,
  input logic                conv_fire,
  input logic                frame_end
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= '0;
    else if (conv_n_o) low_cnt <= '0;
    else               low_cnt <= low_cnt + 1'b1;
  end

  p_conv_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= 16'(PULSE_CYCLES));
  p_conv_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n_o) |-> low_cnt == 16'(PULSE_CYCLES));
  p_conv_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fire |=> !conv_n_o);
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_result_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (valid_o || short_o));
  p_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> word_o[OUT_BITS-1:WORD_BITS] == {(OUT_BITS-WORD_BITS){word_o[WORD_BITS-1]}});
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && short_o));
  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(word_o));
  p_stale_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stale_o |-> valid_o);
endmodule

bind adc_frame_rx adcrx_checker #(
  .WORD_BITS(WORD_BITS), .OUT_BITS(OUT_BITS), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_n_o(conv_n_o), .word_o(word_o),
  .valid_o(valid_o), .short_o(short_o), .stale_o(stale_o),
  .conv_fire(conv_fire), .frame_end(frame_end)
);

// File: tb/tb_adc_frame_rx.sv
module tb_adc_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 4;
  localparam int HALF = 6;
  localparam int NVEC = 6;
  localparam logic [11:0] VEC [NVEC] = '{12'h000, 12'h7FF, 12'h800, 12'hFFF, 12'hA5C, 12'h123};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, busy = 1'b1;
  logic conv_n_o, valid_o, short_o, stale_o;
  logic [15:0] word_o;

  int checks = 0;
  int errors = 0;
  int n_valid = 0;
  int n_short = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .conv_n_o(conv_n_o),
    .adc_sclk_i(sclk), .adc_data_i(sdata), .adc_busy_i(busy),
    .word_o(word_o), .valid_o(valid_o), .short_o(short_o), .stale_o(stale_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o) n_valid++;
    if (rst_n && short_o) n_short++;
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input logic [11:0] w);
    logic signed [15:0] s;
    s = $signed(w);
    return s;
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n);
    @(negedge clk) busy = 1'b0;
    cycles(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i];
      cycles(HALF);
      sclk = 1'b1;
      cycles(HALF);
      sclk = 1'b0;
    end
    cycles(4);
  endtask

  task automatic end_frame(input logic full, input logic [15:0] exp_word,
                           input logic exp_stale, input string req);
    busy = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!valid_o && !short_o, req, "early pulse", {valid_o, short_o}, 0);
    @(posedge clk);
    @(negedge clk);
    check(valid_o == full, req, "valid", valid_o, full);
    check(short_o == !full, req, "short", short_o, !full);
    check(word_o == exp_word, req, "word", word_o, exp_word);
    if (full) check(stale_o == exp_stale, req, "stale", stale_o, exp_stale);
    @(posedge clk);
    @(negedge clk);
    check(!valid_o && !short_o, req, "pulse width", {valid_o, short_o}, 0);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    busy = 1'b1; sclk = 1'b0; sdata = 1'b0; start_i = 1'b0;
    cycles(5);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] last;
    logic [15:0] longbits;
    do_reset();
    @(negedge clk);
    // R9 reset state
    check(conv_n_o == 1'b1, "R9", "conv_n", conv_n_o, 1);
    check(!valid_o && !short_o && !stale_o, "R9", "flags", {valid_o, short_o, stale_o}, 0);
    check(word_o == 16'h0, "R9", "word", word_o, 0);

    // R1 single strobe
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int i = 0; i < PULSE; i++) begin
      check(conv_n_o == 1'b0, "R1", "strobe low", conv_n_o, 0);
      @(negedge clk);
    end
    check(conv_n_o == 1'b1, "R1", "strobe end", conv_n_o, 1);
    cycles(3);

    // R2 retrigger during strobe ignored
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    cycles(PULSE - 2);
    check(conv_n_o == 1'b1, "R2", "strobe not extended", conv_n_o, 1);
    cycles(2);
    check(conv_n_o == 1'b1, "R2", "no second strobe", conv_n_o, 1);

    // R10 serial clock while busy high
    for (int i = 0; i < 5; i++) begin
      sdata = i[0];
      cycles(HALF); sclk = 1'b1;
      cycles(HALF); sclk = 1'b0;
    end
    cycles(6);
    check(n_valid == 0 && n_short == 0, "R10", "pulses outside frame", n_valid + n_short, 0);

    // R8 first frame after reset is stale
    send_bits(16'h0ABC, 12);
    end_frame(1'b1, expect_word(12'hABC), 1'b1, "R8");
    cycles(4);

    // R3 R4 R5 table of words
    for (int v = 0; v < NVEC; v++) begin
      send_bits({4'h0, VEC[v]}, 12);
      end_frame(1'b1, expect_word(VEC[v]), 1'b0, "R4");
      check(word_o[15:12] == {4{VEC[v][11]}}, "R5", "sign bits", word_o[15:12], {4{VEC[v][11]}});
      cycles(4);
    end
    last = expect_word(VEC[NVEC-1]);

    // R6 short frame
    send_bits(16'h005A, 7);
    end_frame(1'b0, last, 1'b0, "R6");
    cycles(4);

    // R7 extra bits ignored
    longbits = 16'h1D37;
    send_bits(longbits, 14);
    end_frame(1'b1, expect_word(longbits[13:2]), 1'b0, "R7");
    cycles(4);

    // R8 a short first frame clears the stale mark
    do_reset();
    cycles(2);
    send_bits(16'h0003, 5);
    end_frame(1'b0, 16'h0000, 1'b0, "R8");
    cycles(4);
    send_bits(16'h0801, 12);
    end_frame(1'b1, expect_word(12'h801), 1'b0, "R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule